// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit turns one indexed operand reference into a 16-bit memory address. The caller presents the four base registers (two index registers, the stack pointer and the program counter), the two 8-bit accumulators, a 3-bit mode code, a base select and a 16-bit constant field, then pulses `req`. The unit adds a sign-extended constant or an unsigned accumulator to the chosen base. It can also step the base by a small signed amount and return the stepped value for write-back. In the two memory-indirect modes it fetches a 16-bit pointer, one byte at a time, and returns that pointer as the address.

The program counter input carries the address of the byte after the current instruction. The combination `{acc_a, acc_b}` serves as the 16-bit accumulator. All address arithmetic wraps modulo 2^16. The direct modes answer one cycle after the request. The indirect modes hold `busy` until the pointer has been read.

Top module: `idx_ea_gen`

## Requirements
- R1: After reset, `done`, `err`, `wb_en`, `rd_req` and `busy` are all 0.
- R2: Mode 0 (short constant) gives `ea` = base + sign-extended `ofs[4:0]`, so the reach is -16..+15. `done` is 1 in the cycle after the request and `wb_en` stays 0. The upper bits of `ofs` are ignored.
- R3: Mode 1 (medium constant) gives `ea` = base + sign-extended `ofs[8:0]`, so the reach is -256..+255, with no write-back.
- R4: Mode 2 (long constant) gives `ea` = base + `ofs`, wrapping modulo 2^16, with no write-back.
- R5: Mode 3 (accumulator) adds an unsigned accumulator to the base: `acc_sel` 0 selects `acc_a`, 1 selects `acc_b`, and 2 or 3 selects `{acc_a, acc_b}`. The base is not written back.
- R6: `base_sel` 0 selects `reg_x`, 1 selects `reg_y`, 2 selects `reg_sp` and 3 selects `reg_pc`. Every mode except 4 and 5 accepts all four.
- R7: Mode 4 (pre-step) takes the step amount from sign-extended `ofs[4:0]`. It gives `ea` = base + step, with `wb_en`=1, `wb_sel`=`base_sel` and `wb_val`=base + step, all in the `done` cycle.
- R8: Mode 5 (post-step) gives `ea` = the unmodified base, with `wb_en`=1 and `wb_val`=base + step.
- R9: In modes 4 and 5, a PC base or a step outside -8..-1 and +1..+8 completes with `err`=1 and `wb_en`=0.
- R10: Mode 6 (indirect, constant) sends one `rd_req` pulse at the address base + `ofs` for the high byte. In the cycle after that `rd_valid`, it sends a second pulse at that address + 1 for the low byte. In the cycle after the second `rd_valid`, `done`=1 and `ea` = {high, low}.
- R11: Mode 7 (indirect, accumulator) behaves like mode 6 but reads the pointer at base + `{acc_a, acc_b}`.
- R12: While `busy` is 1, `req` is ignored. While no read is pending, `rd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start one address computation |
| mode | input | 3 | Addressing mode code 0..7 |
| base_sel | input | 2 | Base register select |
| ofs | input | 16 | Constant offset or step field |
| acc_sel | input | 2 | Accumulator offset select |
| reg_x | input | 16 | First index register |
| reg_y | input | 16 | Second index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Address following the instruction |
| acc_a | input | 8 | High accumulator |
| acc_b | input | 8 | Low accumulator |
| rd_valid | input | 1 | Read byte is valid |
| rd_data | input | 8 | Read byte |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Final address valid (one cycle) |
| err | output | 1 | Illegal auto-step request |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base write-back strobe |
| wb_sel | output | 2 | Base register to write back |
| wb_val | output | 16 | Stepped base value |
| rd_req | output | 1 | Byte read request pulse |
| rd_addr | output | 16 | Byte read address |

## Verification
The hardest states to reach are a second request that arrives in the middle of a pointer fetch and a stray read acknowledge that arrives while the unit is idle. The bench runs a responder with a fixed delay, which opens a window of several busy cycles. It pulses `req` with a direct mode inside that window and expects no extra completion. Separately, it raises `rd_valid` while the unit is idle and then confirms that the next indirect fetch still assembles the right pointer. A base of 0xFFFF with a zero constant forces the low-byte read to wrap to address 0.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
   typedef enum logic [2:0] {
      AM_CST_S = 3'd0,
      AM_CST_M = 3'd1,
      AM_CST_L = 3'd2,
      AM_ACCUM = 3'd3,
      AM_PRE   = 3'd4,
      AM_POST  = 3'd5,
      AM_IND_K = 3'd6,
      AM_IND_D = 3'd7
   } am_mode_e;

   typedef enum logic [1:0] {
      BS_X  = 2'd0,
      BS_Y  = 2'd1,
      BS_SP = 2'd2,
      BS_PC = 2'd3
   } base_sel_e;
endpackage

// File: rtl/idx_base_mux.sv
module idx_base_mux #(
   parameter int AW = 16
) (
   input  logic [1:0]    sel,
   input  logic [AW-1:0] r_x,
   input  logic [AW-1:0] r_y,
   input  logic [AW-1:0] r_sp,
   input  logic [AW-1:0] r_pc,
   output logic [AW-1:0] base,
   output logic          is_pc
);
   import idx_ea_pkg::*;

   always_comb begin
      unique case (base_sel_e'(sel))
         BS_X:    base = r_x;
         BS_Y:    base = r_y;
         BS_SP:   base = r_sp;
         default: base = r_pc;
      endcase
   end

   assign is_pc = (base_sel_e'(sel) == BS_PC);
endmodule

// File: rtl/idx_ofs_calc.sv
module idx_ofs_calc #(
   parameter int AW       = 16,
   parameter int SHORT_W  = 5,
   parameter int MID_W    = 9,
   parameter int AUTO_MAX = 8
) (
   input  logic [2:0]      mode,
   input  logic [AW-1:0]   base,
   input  logic            base_is_pc,
   input  logic [AW-1:0]   ofs,
   input  logic [1:0]      acc_sel,
   input  logic [AW/2-1:0] acc_a,
   input  logic [AW/2-1:0] acc_b,
   output logic [AW-1:0]   sum,
   output logic            auto_mod,
   output logic            post,
   output logic            indirect,
   output logic            bad
);
   import idx_ea_pkg::*;

   localparam int HW = AW / 2;

   logic [AW-1:0]        ext_s, ext_m, acc_v, addend;
   logic signed [AW-1:0] step_s;
   logic                 step_ok;
   am_mode_e             m;

   assign m      = am_mode_e'(mode);
   assign ext_s  = {{(AW-SHORT_W){ofs[SHORT_W-1]}}, ofs[SHORT_W-1:0]};
   assign ext_m  = {{(AW-MID_W){ofs[MID_W-1]}}, ofs[MID_W-1:0]};
   assign step_s = $signed(ext_s);

   always_comb begin
      unique case (acc_sel)
         2'd0:    acc_v = {{HW{1'b0}}, acc_a};
         2'd1:    acc_v = {{HW{1'b0}}, acc_b};
         default: acc_v = {acc_a, acc_b};
      endcase
   end

   always_comb begin
      unique case (m)
         AM_CST_S, AM_PRE, AM_POST: addend = ext_s;
         AM_CST_M:                  addend = ext_m;
         AM_CST_L, AM_IND_K:        addend = ofs;
         AM_ACCUM:                  addend = acc_v;
         default:                   addend = {acc_a, acc_b};
      endcase
   end

   assign sum      = base + addend;
   assign step_ok  = (step_s != '0) && (int'(step_s) <= AUTO_MAX)
                     && (int'(step_s) >= -AUTO_MAX);
   assign auto_mod = (m == AM_PRE) || (m == AM_POST);
   assign post     = (m == AM_POST);
   assign indirect = (m == AM_IND_K) || (m == AM_IND_D);
   assign bad      = auto_mod && (base_is_pc || !step_ok);
endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch #(
   parameter int AW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   addr,
   input  logic            rd_valid,
   input  logic [AW/2-1:0] rd_data,
   output logic            busy,
   output logic            rd_req,
   output logic [AW-1:0]   rd_addr,
   output logic            fin,
   output logic [AW-1:0]   ptr
);
   localparam int HW = AW / 2;

   typedef enum logic [1:0] {PF_IDLE, PF_WAIT_HI, PF_WAIT_LO} pf_state_e;

   pf_state_e      st;
   logic [HW-1:0]  hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PF_IDLE;
         rd_req  <= 1'b0;
         rd_addr <= '0;
         fin     <= 1'b0;
         ptr     <= '0;
         hi_q    <= '0;
      end else begin
         rd_req <= 1'b0;
         fin    <= 1'b0;
         unique case (st)
            PF_IDLE: if (start) begin
               rd_req  <= 1'b1;
               rd_addr <= addr;
               st      <= PF_WAIT_HI;
            end
            PF_WAIT_HI: if (rd_valid) begin
               hi_q    <= rd_data;
               rd_req  <= 1'b1;
               rd_addr <= rd_addr + 1'b1;
               st      <= PF_WAIT_LO;
            end
            default: if (rd_valid) begin
               ptr <= {hi_q, rd_data};
               fin <= 1'b1;
               st  <= PF_IDLE;
            end
         endcase
      end
   end

   assign busy = (st != PF_IDLE);

   // R10
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R10
   lo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && st == PF_WAIT_LO) |-> rd_addr == $past(rd_addr) + 1'b1);

   // R12
   fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> st == PF_IDLE);
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen #(
   parameter int AW       = 16,
   parameter int SHORT_W  = 5,
   parameter int MID_W    = 9,
   parameter int AUTO_MAX = 8,
   parameter bit HAS_IND  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [2:0]    mode,
   input  logic [1:0]    base_sel,
   input  logic [15:0]   ofs,
   input  logic [1:0]    acc_sel,
   input  logic [15:0]   reg_x,
   input  logic [15:0]   reg_y,
   input  logic [15:0]   reg_sp,
   input  logic [15:0]   reg_pc,
   input  logic [7:0]    acc_a,
   input  logic [7:0]    acc_b,
   input  logic          rd_valid,
   input  logic [7:0]    rd_data,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [15:0]   ea,
   output logic          wb_en,
   output logic [1:0]    wb_sel,
   output logic [15:0]   wb_val,
   output logic          rd_req,
   output logic [15:0]   rd_addr
);
   localparam int HW       = AW / 2;
   localparam int STEP_LIM = 2 ** (SHORT_W - 1) - 1;

   generate
      if ((AW != 16) || (SHORT_W >= MID_W) || (MID_W > AW)
          || (AUTO_MAX < 1) || (AUTO_MAX > STEP_LIM)) begin : g_bad_cfg
         $error("idx_ea_gen: inconsistent width or step parameters");
      end
   endgenerate

   logic [AW-1:0] base, sum, ptr;
   logic          is_pc, auto_mod, post, indirect, bad;
   logic          accept, fin;
   logic          done_s;
   logic [AW-1:0] ea_s;

   idx_base_mux #(.AW(AW)) u_bmux (
      .sel(base_sel), .r_x(reg_x), .r_y(reg_y), .r_sp(reg_sp), .r_pc(reg_pc),
      .base(base), .is_pc(is_pc)
   );

   idx_ofs_calc #(.AW(AW), .SHORT_W(SHORT_W), .MID_W(MID_W),
                  .AUTO_MAX(AUTO_MAX)) u_calc (
      .mode(mode), .base(base), .base_is_pc(is_pc), .ofs(ofs),
      .acc_sel(acc_sel), .acc_a(acc_a[HW-1:0]), .acc_b(acc_b[HW-1:0]),
      .sum(sum), .auto_mod(auto_mod), .post(post), .indirect(indirect),
      .bad(bad)
   );

   assign accept = req && !busy;

   generate
      if (HAS_IND) begin : g_ind
         idx_ptr_fetch #(.AW(AW)) u_fetch (
            .clk(clk), .rst_n(rst_n), .start(accept && indirect), .addr(sum),
            .rd_valid(rd_valid), .rd_data(rd_data[HW-1:0]), .busy(busy),
            .rd_req(rd_req), .rd_addr(rd_addr), .fin(fin), .ptr(ptr)
         );
      end else begin : g_no_ind
         assign busy    = 1'b0;
         assign rd_req  = 1'b0;
         assign rd_addr = '0;
         assign fin     = 1'b0;
         assign ptr     = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_s <= 1'b0;
         err    <= 1'b0;
         wb_en  <= 1'b0;
         wb_sel <= '0;
         wb_val <= '0;
         ea_s   <= '0;
      end else begin
         done_s <= 1'b0;
         err    <= 1'b0;
         wb_en  <= 1'b0;
         if (accept && !(indirect && HAS_IND)) begin
            done_s <= 1'b1;
            ea_s   <= post ? base : sum;
            if (bad || indirect) begin
               err <= 1'b1;
            end else if (auto_mod) begin
               wb_en  <= 1'b1;
               wb_sel <= base_sel;
               wb_val <= sum;
            end
         end
      end
   end

   assign done = done_s | fin;
   assign ea   = fin ? ptr : ea_s;

   // R9
   err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wb_en);

   // R9
   wb_not_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_sel != 2'd3);

   // R12
   rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   // R2
   direct_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && mode < 3'd6) |=> done);
endmodule

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  base_sel = '0;
   logic [15:0] ofs = '0;
   logic [1:0]  acc_sel = '0;
   logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3000, reg_pc = 16'hE002;
   logic [7:0]  acc_a = 8'h60, acc_b = 8'h99;
   logic        mem_valid = 1'b0, stray = 1'b0;
   logic        rd_valid;
   logic [7:0]  rd_data = '0;
   logic        busy, done, err, wb_en, rd_req;
   logic [15:0] ea, wb_val, rd_addr;
   logic [1:0]  wb_sel;

   int checks = 0, failures = 0;

   logic [15:0] q_ea[$], q_wv[$], q_rd[$];
   logic        q_wb[$], q_err[$];
   logic [1:0]  q_sel[$];
   string       q_tag[$];

   assign rd_valid = mem_valid | stray;

   always #5 clk = ~clk;

   idx_ea_gen u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .base_sel(base_sel),
      .ofs(ofs), .acc_sel(acc_sel), .reg_x(reg_x), .reg_y(reg_y),
      .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
      .err(err), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
      .rd_req(rd_req), .rd_addr(rd_addr)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic [15:0] base_of(input logic [1:0] bs);
      case (bs)
         2'd0: return reg_x;
         2'd1: return reg_y;
         2'd2: return reg_sp;
         default: return reg_pc;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder: fixed two-cycle latency, compares read addresses
   initial begin
      int pend = 0;
      logic [15:0] pa = '0;
      forever begin
         @(negedge clk);
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_valid = 1'b1;
               rd_data   = mem_byte(pa);
            end
         end else begin
            mem_valid = 1'b0;
         end
         if (rd_req) begin
            pa   = rd_addr;
            pend = 2;
            if (q_rd.size() == 0) begin
               chk(1'b0, "R12 unexpected read", rd_addr, 16'h0);
            end else begin
               logic [15:0] e;
               e = q_rd.pop_front();
               chk(rd_addr == e, "R10/R11 read address", rd_addr, e);
            end
         end
      end
   end

   // monitor: pops scoreboard on every done
   initial begin
      forever begin
         @(negedge clk);
         if (done && rst_n) begin
            if (q_ea.size() == 0) begin
               chk(1'b0, "R12 unexpected done", ea, 16'h0);
            end else begin
               logic [15:0] e_ea, e_wv;
               logic        e_wb, e_err;
               logic [1:0]  e_sel;
               string       t;
               e_ea = q_ea.pop_front(); e_wv = q_wv.pop_front();
               e_wb = q_wb.pop_front(); e_err = q_err.pop_front();
               e_sel = q_sel.pop_front(); t = q_tag.pop_front();
               chk(err == e_err, {t, " err"}, {15'd0, err}, {15'd0, e_err});
               chk(wb_en == e_wb, {t, " wb_en"}, {15'd0, wb_en}, {15'd0, e_wb});
               if (!e_err) chk(ea == e_ea, {t, " ea"}, ea, e_ea);
               if (e_wb) begin
                  chk(wb_val == e_wv, {t, " wb_val"}, wb_val, e_wv);
                  chk(wb_sel == e_sel, {t, " wb_sel"}, {14'd0, wb_sel}, {14'd0, e_sel});
               end
            end
         end
      end
   end

   task automatic run(input logic [2:0] m, input logic [1:0] bs,
                      input logic [15:0] o, input logic [1:0] as,
                      input logic [15:0] e_ea, input logic e_wb,
                      input logic [15:0] e_wv, input logic e_err,
                      input string tag);
      int n = 0;
      q_ea.push_back(e_ea); q_wv.push_back(e_wv); q_wb.push_back(e_wb);
      q_err.push_back(e_err); q_sel.push_back(bs); q_tag.push_back(tag);
      @(negedge clk);
      mode = m; base_sel = bs; ofs = o; acc_sel = as; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      n = 1;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
      end
      if (m < 3'd6) chk(n == 1, {tag, " latency"}, 16'(n), 16'd1);
      else          chk(done, {tag, " indirect completes"}, {15'd0, done}, 16'd1);
   endtask

   task automatic run_ind(input logic [2:0] m, input logic [1:0] bs,
                          input logic [15:0] o, input string tag);
      logic [15:0] a;
      a = base_of(bs) + ((m == 3'd6) ? o : {acc_a, acc_b});
      q_rd.push_back(a);
      q_rd.push_back(a + 16'd1);
      run(m, bs, o, 2'd0, {mem_byte(a), mem_byte(a + 16'd1)}, 1'b0, 16'h0,
          1'b0, tag);
   endtask

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({done, err, wb_en, rd_req, busy} == 5'b0, "R1 reset outputs",
          {11'd0, done, err, wb_en, rd_req, busy}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({done, err, wb_en, rd_req, busy} == 5'b0, "R1 after release",
          {11'd0, done, err, wb_en, rd_req, busy}, 16'h0);

      // R2 short constant, upper ofs bits ignored
      run(3'd0, 2'd0, 16'hAB1A, 2'd0, 16'h0FFA, 1'b0, 16'h0, 1'b0, "R2 -6 on X");
      run(3'd0, 2'd1, 16'h000F, 2'd0, 16'h200F, 1'b0, 16'h0, 1'b0, "R2 +15 on Y");
      run(3'd0, 2'd2, 16'h0010, 2'd0, 16'h2FF0, 1'b0, 16'h0, 1'b0, "R2 -16 on SP");
      // R3 medium constant
      run(3'd1, 2'd2, 16'h1F06, 2'd0, 16'h2F06, 1'b0, 16'h0, 1'b0, "R3 -250 on SP");
      run(3'd1, 2'd0, 16'h00FF, 2'd0, 16'h10FF, 1'b0, 16'h0, 1'b0, "R3 +255 on X");
      // R4 long constant with wrap
      reg_y = 16'hA000;
      run(3'd2, 2'd1, 16'hB000, 2'd0, 16'h5000, 1'b0, 16'h0, 1'b0, "R4 wrap on Y");
      run(3'd2, 2'd0, 16'h0700, 2'd0, 16'h1700, 1'b0, 16'h0, 1'b0, "R4 +0x700 on X");
      // R5 accumulator offsets, unsigned
      run(3'd3, 2'd0, 16'h0, 2'd0, 16'h1060, 1'b0, 16'h0, 1'b0, "R5 A on X");
      run(3'd3, 2'd0, 16'h0, 2'd1, 16'h1099, 1'b0, 16'h0, 1'b0, "R5 B unsigned");
      run(3'd3, 2'd0, 16'h0, 2'd2, 16'h7099, 1'b0, 16'h0, 1'b0, "R5 D on X");
      // R6 PC base
      run(3'd0, 2'd3, 16'h0002, 2'd0, 16'hE004, 1'b0, 16'h0, 1'b0, "R6 PC base");
      run(3'd3, 2'd3, 16'h0, 2'd1, 16'hE09B, 1'b0, 16'h0, 1'b0, "R6 PC accum");
      // R7 pre-step
      run(3'd4, 2'd0, 16'h001F, 2'd0, 16'h0FFF, 1'b1, 16'h0FFF, 1'b0, "R7 pre -1 X");
      run(3'd4, 2'd1, 16'h0008, 2'd0, 16'hA008, 1'b1, 16'hA008, 1'b0, "R7 pre +8 Y");
      // R8 post-step
      run(3'd5, 2'd2, 16'h0002, 2'd0, 16'h3000, 1'b1, 16'h3002, 1'b0, "R8 post +2 SP");
      run(3'd5, 2'd0, 16'h0018, 2'd0, 16'h1000, 1'b1, 16'h0FF8, 1'b0, "R8 post -8 X");
      // R9 illegal auto-step
      run(3'd4, 2'd3, 16'h0001, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, "R9 PC base");
      run(3'd5, 2'd0, 16'h0000, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, "R9 zero step");
      run(3'd4, 2'd0, 16'h0009, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, "R9 step +9");
      run(3'd5, 2'd1, 16'h0017, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, "R9 step -9");
      // R10 indirect constant
      run_ind(3'd6, 2'd0, 16'h0004, "R10 X+4");
      reg_y = 16'hFFFF;
      run_ind(3'd6, 2'd1, 16'h0000, "R10 wrap FFFF");
      // R11 indirect accumulator
      acc_a = 8'h00; acc_b = 8'h04;
      run_ind(3'd7, 2'd0, 16'h0, "R11 X+D");
      acc_a = 8'h12; acc_b = 8'h34;
      run_ind(3'd7, 2'd3, 16'h0, "R11 PC+D");

      // R12 request during busy ignored
      begin
         logic [15:0] a;
         a = reg_sp + 16'h0100;
         q_rd.push_back(a); q_rd.push_back(a + 16'd1);
         q_ea.push_back({mem_byte(a), mem_byte(a + 16'd1)}); q_wv.push_back(16'h0);
         q_wb.push_back(1'b0); q_err.push_back(1'b0); q_sel.push_back(2'd2);
         q_tag.push_back("R12 fetch with extra req");
         @(negedge clk);
         mode = 3'd6; base_sel = 2'd2; ofs = 16'h0100; req = 1'b1;
         @(negedge clk);
         req = 1'b0;
         @(negedge clk);
         chk(busy, "R12 busy during fetch", {15'd0, busy}, 16'd1);
         mode = 3'd2; base_sel = 2'd0; ofs = 16'h0001; req = 1'b1;
         @(negedge clk);
         req = 1'b0;
         repeat (12) @(negedge clk);
         chk(q_ea.size() == 0, "R12 only one completion",
             16'(q_ea.size()), 16'd0);
      end
      // R12 stray rd_valid while idle
      @(negedge clk);
      stray = 1'b1;
      @(negedge clk);
      stray = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_req, "R12 stray valid idle",
          {13'd0, busy, done, rd_req}, 16'h0);
      run_ind(3'd6, 2'd0, 16'h0020, "R12 fetch after stray");

      repeat (5) @(negedge clk);
      chk(q_rd.size() == 0 && q_ea.size() == 0, "R10 scoreboard drained",
          16'(q_rd.size() + q_ea.size()), 16'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule